// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block computes the arithmetic negation of a signed two's complement word one bit per clock, least significant bit first. It does not invert the word and then increment it. It keeps a single flag that tracks whether a one has been seen yet in the bits scanned so far. While the flag is clear, each input bit passes through unchanged; this covers the low zeros and the first one. Once the flag is set, every later bit is inverted.

A one-cycle `start` pulse loads a parallel operand while the block is idle. The negated bits then stream out on `neg_bit`, qualified by `neg_vld`, over `WIDTH` consecutive cycles. At the same time the block assembles the parallel result. After the last serial bit it raises `done` for one cycle, and the parallel result and the overflow flag appear together. Both hold until the next conversion ends. The one input that cannot be negated is the most negative value, which maps onto itself, and that case raises `overflow`.

Top module: `bsn_negator`

## Requirements
- R1: After reset, `busy`, `neg_vld`, `done` and `overflow` are 0 and `result` is all zeros.
- R2: A `start` pulse seen at a clock edge while `busy` is 0 loads `operand`. `neg_vld` is then 1 for exactly `WIDTH` consecutive cycles, beginning in the cycle that follows that edge.
- R3: Serial bit k (k = 0 first, the least significant) equals operand bit k when no operand bit below k is 1, and equals the inverse of operand bit k otherwise.
- R4: In the `done` cycle, `result` equals (~operand + 1) mod 2^WIDTH. It stays unchanged in every cycle until the next `done`.
- R5: `done` is a single-cycle pulse. It arrives in the cycle right after the last serial bit, and `neg_vld` is 0 during that cycle.
- R6: An all-zero operand gives an all-zero serial stream and result, with `overflow` at 0.
- R7: `overflow` is 1 exactly when the converted operand is the most negative value (top bit 1, all other bits 0); in that case `result` equals the operand. It updates together with `result`.
- R8: `start` is ignored while `busy` is 1. The running conversion keeps its operand, its bit stream and its timing.
- R9: A `start` in the `done` cycle is accepted, so conversions can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load request, honoured only when idle |
| operand | input | WIDTH | Signed word to negate |
| busy | output | 1 | Conversion in progress |
| neg_bit | output | 1 | Current serial result bit, LSB first |
| neg_vld | output | 1 | Qualifies `neg_bit` |
| result | output | WIDTH | Parallel negated word, updated at `done` |
| done | output | 1 | One-cycle end-of-conversion pulse |
| overflow | output | 1 | Operand was the most negative value |

## Verification
The assertions check the cycle-level rules on every cycle. These cover the stream length counted from the accepting edge, the single-cycle `done` with `neg_vld` low, the stability of `result` outside `done`, and the link between `overflow` and the most negative pattern. Bit values depend on the operand, so only the bench's scenarios can confirm them. The bench runs every 8-bit operand and then random ones, and compares each serial bit and parallel word with an invert-and-add-one reference. Rejection of `start` while busy and back-to-back acceptance are also shown only by bench scenarios that drive those patterns.

// File: rtl/bsn_pkg.sv
package bsn_pkg;
   // Width of the bit counter needed for a given word width
   function automatic int cnt_bits(input int w);
      return (w > 1) ? $clog2(w) : 1;
   endfunction
endpackage

// File: rtl/bsn_ctrl.sv
module bsn_ctrl #(
   parameter int WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic last,
   output logic busy,
   output logic done
);
   localparam int CW = bsn_pkg::cnt_bits(WIDTH);
   localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   assign load = start && !busy_q;
   assign step = busy_q;
   assign last = busy_q && (cnt_q == LAST_IDX);
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (load) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (last) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bsn_shifter.sv
module bsn_shifter #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] operand,
   output logic             in_bit
);
   logic [WIDTH-1:0] sreg_q;

   assign in_bit = sreg_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg_q <= '0;
      else if (load)
         sreg_q <= operand;
      else if (step)
         sreg_q <= {1'b0, sreg_q[WIDTH-1:1]};
   end
endmodule

// File: rtl/bsn_cell.sv
module bsn_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   input  logic in_bit,
   output logic out_bit,
   output logic any_one
);
   // Flag: a one has already passed in this conversion
   logic seen_q;

   assign out_bit = in_bit ^ seen_q;
   assign any_one = seen_q | in_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= 1'b0;
      else if (load)
         seen_q <= 1'b0;
      else if (step)
         seen_q <= seen_q | in_bit;
   end
endmodule

// File: rtl/bsn_collect.sv
module bsn_collect #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             last,
   input  logic             in_bit,
   input  logic             out_bit,
   input  logic             any_one,
   output logic [WIDTH-1:0] result,
   output logic             overflow
);
   logic [WIDTH-1:0] shadow_q;
   logic [WIDTH-1:0] result_q;
   logic             ovf_q;
   logic [WIDTH-1:0] shadow_nx;

   assign shadow_nx = {out_bit, shadow_q[WIDTH-1:1]};
   assign result    = result_q;
   assign overflow  = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         result_q <= '0;
         ovf_q    <= 1'b0;
      end else begin
         if (step)
            shadow_q <= shadow_nx;
         if (last) begin
            result_q <= shadow_nx;
            // sign in set, sign out set, operand nonzero
            ovf_q    <= in_bit & out_bit & any_one;
         end
      end
   end
endmodule

// File: rtl/bsn_negator.sv
module bsn_negator #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] operand,
   output logic             busy,
   output logic             neg_bit,
   output logic             neg_vld,
   output logic [WIDTH-1:0] result,
   output logic             done,
   output logic             overflow
);
   generate
      if (WIDTH < 2) begin : g_width_check
         $error("bsn_negator: WIDTH must be at least 2");
      end
   endgenerate

   logic load, step, last;
   logic in_bit, out_bit, any_one;

   bsn_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .last  (last),
      .busy  (busy),
      .done  (done)
   );

   bsn_shifter #(.WIDTH(WIDTH)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .operand (operand),
      .in_bit  (in_bit)
   );

   bsn_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .in_bit  (in_bit),
      .out_bit (out_bit),
      .any_one (any_one)
   );

   bsn_collect #(.WIDTH(WIDTH)) u_coll (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .last     (last),
      .in_bit   (in_bit),
      .out_bit  (out_bit),
      .any_one  (any_one),
      .result   (result),
      .overflow (overflow)
   );

   assign neg_bit = out_bit & step;
   assign neg_vld = step;
endmodule

// File: rtl/bsn_negator_chk.sv
module bsn_negator_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             neg_vld,
   input logic [WIDTH-1:0] result,
   input logic             done,
   input logic             overflow
);
   localparam int VW = $clog2(WIDTH + 1) + 1;
   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   logic [VW-1:0] vcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vcnt_q <= '0;
      else if (start && !busy)
         vcnt_q <= '0;
      else if (neg_vld)
         vcnt_q <= vcnt_q + 1'b1;
   end

   assert_run_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(neg_vld) |-> $past(start));

   assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (vcnt_q == VW'(WIDTH)));

   assert_no_long_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      neg_vld |-> (vcnt_q < VW'(WIDTH)));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!neg_vld && $past(neg_vld)));

   assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (result != MOST_NEG) |-> !overflow);

   assert_overflow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(overflow));
endmodule

bind bsn_negator bsn_negator_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .neg_vld  (neg_vld),
   .result   (result),
   .done     (done),
   .overflow (overflow)
);

// File: tb/bsn_negator_test.sv
module bsn_negator_test;
   localparam int W = 8;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] operand = '0;
   logic         busy, neg_bit, neg_vld, done, overflow;
   logic [W-1:0] result;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   bsn_negator #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
      .busy(busy), .neg_bit(neg_bit), .neg_vld(neg_vld),
      .result(result), .done(done), .overflow(overflow)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [W-1:0] ref_neg(input logic [W-1:0] x);
      return ~x + 1'b1;
   endfunction

   function automatic logic ref_ovf(input logic [W-1:0] x);
      return x == {1'b1, {(W-1){1'b0}}};
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Starts a conversion at the next negedge; noise drives start while busy.
   // On return we sit on the done-cycle negedge with start held low
   // unless chain_next is set, in which case start is raised with nxt.
   task automatic convert(input logic [W-1:0] x, input bit noise,
                          input bit chain_next, input logic [W-1:0] nxt);
      logic [W-1:0] exp;
      exp = ref_neg(x);
      @(negedge clk);
      start = 1'b1;
      operand = x;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < W; k++) begin
         check(neg_vld == 1'b1, "R2 neg_vld", W'(neg_vld), W'(1));
         check(neg_bit == exp[k], "R3 serial bit", W'(neg_bit), W'(exp[k]));
         if (noise) begin
            start = ($urandom % 2) == 1;
            operand = W'($urandom);
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(done == 1'b1 && neg_vld == 1'b0, "R5 done pulse", W'({done, neg_vld}), W'(2'b10));
      check(result == exp, noise ? "R8 result under start noise" : "R4 result", result, exp);
      check(overflow == ref_ovf(x), "R7 overflow", W'(overflow), W'(ref_ovf(x)));
      if (x == '0)
         check(result == '0 && !overflow, "R6 zero", result, '0);
      if (chain_next) begin
         start = 1'b1;
         operand = nxt;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check(!busy && !neg_vld && !done && !overflow && result == '0,
            "R1 reset state", result, '0);
      rst_n = 1'b1;

      // Directed corners
      convert(8'h3C, 1'b0, 1'b0, '0);
      convert(8'h05, 1'b0, 1'b0, '0);
      convert(8'h00, 1'b0, 1'b0, '0);
      convert(8'h80, 1'b0, 1'b0, '0);
      convert(8'hFF, 1'b0, 1'b0, '0);
      convert(8'h7F, 1'b0, 1'b0, '0);

      // R4 hold: result and overflow stay while idle
      @(negedge clk);
      check(!done, "R5 done single cycle", W'(done), W'(0));
      check(result == ref_neg(8'h7F), "R4 hold while idle", result, ref_neg(8'h7F));

      // R9 back to back: start in the done cycle
      convert(8'h80, 1'b0, 1'b1, 8'h01);
      @(negedge clk);
      start = 1'b0;
      check(neg_vld == 1'b1, "R9 back-to-back accept", W'(neg_vld), W'(1));
      for (int k = 0; k < W; k++) begin
         check(neg_bit == ref_neg(8'h01)[k], "R9 serial bit", W'(neg_bit),
               W'(ref_neg(8'h01)[k]));
         @(negedge clk);
      end
      check(done && result == 8'hFF && !overflow, "R9 result", result, 8'hFF);

      // Exhaustive sweep
      for (int v = 0; v < (1 << W); v++)
         convert(W'(v), 1'b0, 1'b0, '0);

      // Random operands with start noise during busy (R8)
      for (int n = 0; n < 300; n++)
         convert(W'($urandom), 1'b1, 1'b0, '0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule